// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing protocol engine of a 2048-byte serial memory that sits on a two-wire I2C bus. Up to eight such memories can share the bus. It samples the bus clock and data lines with the system clock and finds START and STOP conditions. It shifts bytes in and out, answers its own device address and drives the data line low through an open-drain enable. Bytes written by the master go to an external page buffer, together with their word address. Bytes read by the master come from an external synchronous memory port.

The first byte of every transfer selects the device. It also carries the three upper bits of the 11-bit word address. In a write, the byte after it sets the lower eight bits. In a read, the engine continues from the address held in its counter, which makes current-address reads possible. Combining a short write with a repeated START gives random reads.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, and after any STOP, the engine takes no notice of SCL/SDA activity until a START occurs (SDA falling while SCL is high). Bytes clocked without a START get no ACK.
- R2: The first byte after START is taken MSB first as {1, A2, A1, A0, w10, w9, w8, rw}. The engine responds only when bit 7 is 1, A2 equals strap_i[2], A1 equals the inverse of strap_i[1] and A0 equals strap_i[0]. Otherwise it drives nothing until the next START or STOP.
- R3: While wr_busy_i is high when the address byte completes, the engine does not acknowledge that byte.
- R4: The engine drives SDA low (sda_oe_o=1) for the whole 9th SCL high phase after a matching address byte and after every byte written to it.
- R5: In a write, the byte after the address byte loads word address bits 7:0 and is not handed on. Each later byte gives a one-cycle wr_valid_o pulse with wr_addr_o set to the current word address and wr_data_o set to the byte. The address then steps by one modulo 2048.
- R6: wr_commit_o pulses for one cycle on a STOP that ends a write in which at least one data byte was handed on. A read, a write with no data, or a write cut short by a repeated START gives no pulse.
- R7: In a read, data goes out MSB first. Each bit changes only after an SCL falling edge, and SDA is released for the 9th clock. A master ACK (SDA low at the 9th rise) starts the next byte. A NoACK leaves SDA released until the next START or STOP.
- R8: Every matching address byte loads word address bits 10:8 from its w10..w8 field and keeps bits 7:0. Each byte read returns the memory at the current address, and the address then advances by one, wrapping from 2047 to 0.
- R9: A STOP or START at any bit position drops the bit in progress. A START goes straight to the address phase.
- R10: sda_oe_o is low in reset, while idle and while the master drives the data bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (resolved line) |
| strap_i | input | 3 | Device-select straps {A2, A1, A0} |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Memory read data, one cycle after rd_en_o |
| sda_oe_o | output | 1 | Pull SDA low when high |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | 11 | Memory read address |
| wr_valid_o | output | 1 | Write byte to page buffer |
| wr_addr_o | output | 11 | Word address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | Start the internal write cycle |

## Verification
The bench builds the engine with the default two-stage synchronizer and straps set to 3'b110. With these straps the A1 device bit must read 0 while the pin is 1. This separates the inverted match from a plain one, and a wrong A2 or A0 bit each fails in its own way. A bus phase of eight system clocks gives more time than the sync and fetch latency needs. Every ACK and data bit can therefore be sampled in mid-high, while the word address still covers the 2047-to-0 wrap in both reads and writes.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int HI_W = 3;
  localparam int LO_W = 8;
  localparam int AW   = HI_W + LO_W;
  localparam int BW   = 8;
  localparam int CW   = $clog2(BW + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } xfer_st_e;
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_word_addr.sv
module i2c_word_addr
  import i2c_mem_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_hi_i,
  input  logic [HI_W-1:0] hi_i,
  input  logic            ld_lo_i,
  input  logic [LO_W-1:0] lo_i,
  input  logic            inc_i,
  output logic [AW-1:0]   addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (inc_i) begin
      addr_q <= addr_q + 1'b1;
    end else begin
      if (ld_hi_i) addr_q[AW-1:LO_W] <= hi_i;
      if (ld_lo_i) addr_q[LO_W-1:0]  <= lo_i;
    end
  end

  assign addr_o = addr_q;

  // R8
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> addr_q == $past(addr_q) + 11'd1);

  // R8
  addr_keep_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hi_i && !ld_lo_i && !inc_i) |=> addr_q[LO_W-1:0] == $past(addr_q[LO_W-1:0]));
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_mem_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sda_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [2:0]      strap_i,
  input  logic            wr_busy_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [BW-1:0]   rd_data_i,
  output logic            ld_hi_o,
  output logic [HI_W-1:0] hi_o,
  output logic            ld_lo_o,
  output logic [LO_W-1:0] lo_o,
  output logic            inc_o,
  output logic            sda_oe_o,
  output logic            rd_en_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            wr_valid_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [BW-1:0]   wr_data_o,
  output logic            wr_commit_o
);
  xfer_st_e      state_q;
  logic [CW-1:0] bit_q;
  logic [BW-1:0] rx_q, tx_q, byte_now;
  logic          rw_q, ack_on_q, oe_q, wr_any_q;
  logic          rd_en_q, rd_cap_q;
  logic [AW-1:0] rd_addr_q;
  logic          wr_valid_q, commit_q;
  logic [AW-1:0] wr_addr_q;
  logic [BW-1:0] wr_data_q;
  logic          last_bit, dev_hit, quiet;

  assign byte_now = {rx_q[BW-2:0], sda_i};
  assign last_bit = scl_rise_i && (bit_q == CW'(BW - 1));
  assign quiet    = !start_i && !stop_i;
  assign dev_hit  = byte_now[7] && (byte_now[6] == strap_i[2]) &&
                    (byte_now[5] == ~strap_i[1]) && (byte_now[4] == strap_i[0]) &&
                    !wr_busy_i;

  always_comb begin
    ld_hi_o = 1'b0;
    ld_lo_o = 1'b0;
    inc_o   = 1'b0;
    hi_o    = byte_now[3:1];
    lo_o    = byte_now;
    if (quiet && last_bit) begin
      unique case (state_q)
        ST_DEV:   ld_hi_o = dev_hit;
        ST_WADDR: ld_lo_o = 1'b1;
        ST_WDATA: inc_o   = 1'b1;
        ST_RDATA: inc_o   = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      ack_on_q   <= 1'b0;
      oe_q       <= 1'b0;
      wr_any_q   <= 1'b0;
      rd_en_q    <= 1'b0;
      rd_cap_q   <= 1'b0;
      rd_addr_q  <= '0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      commit_q   <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      rd_en_q    <= 1'b0;
      rd_cap_q   <= rd_en_q;
      if (rd_cap_q) tx_q <= rd_data_i;
      if (start_i) begin
        state_q  <= ST_DEV;
        bit_q    <= '0;
        oe_q     <= 1'b0;
        ack_on_q <= 1'b0;
        wr_any_q <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        ack_on_q <= 1'b0;
        commit_q <= wr_any_q;
        wr_any_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise_i) begin
              rx_q  <= byte_now;
              bit_q <= bit_q + 1'b1;
            end
            if (last_bit) begin
              ack_on_q <= 1'b0;
              if (state_q == ST_DEV) begin
                if (dev_hit) begin
                  state_q <= ST_DEV_ACK;
                  rw_q    <= byte_now[0];
                  if (byte_now[0]) begin
                    rd_en_q   <= 1'b1;
                    rd_addr_q <= {byte_now[3:1], addr_i[LO_W-1:0]};
                  end
                end else begin
                  state_q <= ST_SKIP;
                end
              end else if (state_q == ST_WADDR) begin
                state_q <= ST_WADDR_ACK;
              end else begin
                state_q    <= ST_WDATA_ACK;
                wr_valid_q <= 1'b1;
                wr_addr_q  <= addr_i;
                wr_data_q  <= byte_now;
                wr_any_q   <= 1'b1;
              end
            end
          end
          ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              if (!ack_on_q) begin
                oe_q     <= 1'b1;
                ack_on_q <= 1'b1;
              end else begin
                ack_on_q <= 1'b0;
                bit_q    <= '0;
                if (state_q == ST_DEV_ACK && rw_q) begin
                  state_q <= ST_RDATA;
                  oe_q    <= ~tx_q[BW-1];
                  tx_q    <= {tx_q[BW-2:0], 1'b0};
                end else begin
                  oe_q    <= 1'b0;
                  state_q <= (state_q == ST_DEV_ACK) ? ST_WADDR : ST_WDATA;
                end
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              bit_q <= bit_q + 1'b1;
              if (last_bit) begin
                rd_en_q   <= 1'b1;
                rd_addr_q <= addr_i + 1'b1;
              end
            end else if (scl_fall_i) begin
              if (bit_q == CW'(BW)) begin
                oe_q     <= 1'b0;
                state_q  <= ST_RACK;
                ack_on_q <= 1'b0;
              end else begin
                oe_q <= ~tx_q[BW-1];
                tx_q <= {tx_q[BW-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              if (!sda_i) ack_on_q <= 1'b1;
              else        state_q  <= ST_SKIP;
            end else if (scl_fall_i && ack_on_q) begin
              state_q  <= ST_RDATA;
              bit_q    <= '0;
              ack_on_q <= 1'b0;
              oe_q     <= ~tx_q[BW-1];
              tx_q     <= {tx_q[BW-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign rd_en_o     = rd_en_q;
  assign rd_addr_o   = rd_addr_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = commit_q;

  // R10
  oe_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (state_q inside {ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_RDATA}));

  // R9
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!oe_q && state_q == ST_DEV && bit_q == '0));

  // R3
  busy_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV && wr_busy_i && quiet) |=> state_q != ST_DEV_ACK);

  // R5
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_q |=> !wr_valid_q);

  // R6
  commit_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> $past(stop_i));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE && !oe_q));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          wr_busy_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic          rd_en_o,
  output logic [10:0]   rd_addr_o,
  output logic          wr_valid_o,
  output logic [10:0]   wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o
);
  logic            sda_s, scl_rise, scl_fall, start, stop;
  logic            ld_hi, ld_lo, inc;
  logic [HI_W-1:0] hi;
  logic [LO_W-1:0] lo;
  logic [AW-1:0]   addr;

  i2c_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_word_addr u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_hi_i (ld_hi),
    .hi_i    (hi),
    .ld_lo_i (ld_lo),
    .lo_i    (lo),
    .inc_i   (inc),
    .addr_o  (addr)
  );

  i2c_xfer_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start),
    .stop_i      (stop),
    .strap_i     (strap_i),
    .wr_busy_i   (wr_busy_i),
    .addr_i      (addr),
    .rd_data_i   (rd_data_i),
    .ld_hi_o     (ld_hi),
    .hi_o        (hi),
    .ld_lo_o     (ld_lo),
    .lo_o        (lo),
    .inc_o       (inc),
    .sda_oe_o    (sda_oe_o),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .wr_valid_o  (wr_valid_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_commit_o (wr_commit_o)
  );
endmodule

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wr_busy = 1'b0;
  logic [7:0] rd_data = '0;
  logic sda_oe, rd_en, wr_valid, wr_commit;
  logic [10:0] rd_addr, wr_addr;
  logic [7:0] wr_data;
  logic sda_line;

  int total = 0;
  int bad = 0;
  int commits = 0;
  bit finished = 1'b0;
  int exp_wa[$];
  int exp_wd[$];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_slave u_i2c_mem_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .strap_i     (STRAP),
    .wr_busy_i   (wr_busy),
    .rd_data_i   (rd_data),
    .sda_oe_o    (sda_oe),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .wr_valid_o  (wr_valid),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_commit_o (wr_commit)
  );

  function automatic logic [7:0] byte_at(input int a);
    return 8'((a * 73 + 19) ^ (a >> 3));
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= byte_at(int'(rd_addr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the write handoff against the model queue (R5)
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_wa.size() == 0) chk(1'b0, "R5 unexpected write", int'(wr_addr), -1);
      else begin
        int ea, ed;
        ea = exp_wa.pop_front();
        ed = exp_wd.pop_front();
        chk(int'(wr_addr) == ea, "R5 write addr", int'(wr_addr), ea);
        chk(int'(wr_data) == ed, "R5 write data", int'(wr_data), ed);
      end
    end
    if (rst_n && wr_commit) commits++;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input bit b, output bit seen);
    sda_m = b; wq(); scl = 1'b1;
    repeat (Q / 2) @(negedge clk);
    seen = sda_line;
    repeat (Q / 2) @(negedge clk);
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!mack, s);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] hi, input bit rd);
    return {1'b1, STRAP[2], ~STRAP[1], STRAP[0], hi, rd};
  endfunction

  initial begin
    bit ack, s;
    logic [7:0] d;
    int c0;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10 reset oe", int'(sda_oe), 0);
    chk(wr_valid == 1'b0 && wr_commit == 1'b0 && rd_en == 1'b0, "R10 reset outputs",
        int'({wr_valid, wr_commit, rd_en}), 0);
    rst_n = 1'b1;
    wq();

    // R1 no START: matching byte gets no ACK
    scl = 1'b0; wq();
    send_byte(dev(3'b010, 1'b0), ack);
    chk(!ack, "R1 no start no ack", int'(ack), 0);
    send_byte(8'h34, ack);
    chk(!ack, "R1 no start data ignored", int'(ack), 0);
    bus_stop();

    // R4 R5 R6 write with handoff
    bus_start();
    send_byte(dev(3'b010, 1'b0), ack);
    chk(ack, "R4 address ack", int'(ack), 1);
    send_byte(8'h34, ack);
    chk(ack, "R4 word address ack", int'(ack), 1);
    exp_wa.push_back(11'h234); exp_wd.push_back(8'hA1);
    exp_wa.push_back(11'h235); exp_wd.push_back(8'h5C);
    exp_wa.push_back(11'h236); exp_wd.push_back(8'h07);
    send_byte(8'hA1, ack); chk(ack, "R4 data ack 0", int'(ack), 1);
    send_byte(8'h5C, ack); chk(ack, "R4 data ack 1", int'(ack), 1);
    send_byte(8'h07, ack); chk(ack, "R4 data ack 2", int'(ack), 1);
    bus_stop();
    wq();
    chk(commits == 1, "R6 commit after write", commits, 1);
    chk(exp_wa.size() == 0, "R5 all bytes handed", exp_wa.size(), 0);

    // R2 address mismatches
    bus_start();
    send_byte({1'b1, STRAP[2], STRAP[1], STRAP[0], 3'b000, 1'b0}, ack);
    chk(!ack, "R2 A1 equal to pin", int'(ack), 0);
    send_byte(8'h55, ack);
    chk(!ack, "R2 skip after mismatch", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte({1'b1, ~STRAP[2], ~STRAP[1], STRAP[0], 3'b000, 1'b1}, ack);
    chk(!ack, "R2 A2 wrong", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte({1'b1, STRAP[2], ~STRAP[1], ~STRAP[0], 3'b000, 1'b0}, ack);
    chk(!ack, "R2 A0 wrong", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte({1'b0, STRAP[2], ~STRAP[1], STRAP[0], 3'b000, 1'b0}, ack);
    chk(!ack, "R2 msb zero", int'(ack), 0);
    bus_stop();

    // R3 busy
    wr_busy = 1'b1;
    bus_start();
    send_byte(dev(3'b000, 1'b0), ack);
    chk(!ack, "R3 busy nak", int'(ack), 0);
    bus_stop();
    wr_busy = 1'b0;

    // R7 R8 random read, sequential
    bus_start();
    send_byte(dev(3'b101, 1'b0), ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(dev(3'b101, 1'b1), ack);
    chk(ack, "R4 read address ack", int'(ack), 1);
    recv_byte(1'b1, d); chk(d == byte_at(11'h5FE), "R7 read byte 0", int'(d), int'(byte_at(11'h5FE)));
    recv_byte(1'b1, d); chk(d == byte_at(11'h5FF), "R8 read byte 1", int'(d), int'(byte_at(11'h5FF)));
    recv_byte(1'b0, d); chk(d == byte_at(11'h600), "R8 read byte 2", int'(d), int'(byte_at(11'h600)));
    bus_stop();
    wq();
    chk(commits == 1, "R6 no commit on read", commits, 1);

    // R8 current address read with new high bits
    bus_start();
    send_byte(dev(3'b110, 1'b1), ack);
    recv_byte(1'b0, d);
    chk(d == byte_at(11'h601), "R8 current address", int'(d), int'(byte_at(11'h601)));
    bus_stop();

    // R8 wrap on read, R7 released after NoACK
    bus_start();
    send_byte(dev(3'b111, 1'b0), ack);
    send_byte(8'hFF, ack);
    bus_start();
    send_byte(dev(3'b111, 1'b1), ack);
    recv_byte(1'b1, d); chk(d == byte_at(11'h7FF), "R8 last location", int'(d), int'(byte_at(11'h7FF)));
    recv_byte(1'b0, d); chk(d == byte_at(0), "R8 wrap to zero", int'(d), int'(byte_at(0)));
    recv_byte(1'b0, d); chk(d == 8'hFF, "R7 released after noack", int'(d), 8'hFF);
    bus_stop();

    // R9 STOP mid-byte drops the bit, counter kept
    c0 = commits;
    bus_start();
    send_byte(dev(3'b000, 1'b0), ack);
    send_byte(8'h10, ack);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    bus_stop();
    wq();
    chk(commits == c0, "R9 stop mid byte no commit", commits, c0);
    bus_start();
    send_byte(dev(3'b000, 1'b1), ack);
    recv_byte(1'b0, d);
    chk(d == byte_at(11'h010), "R9 read after abort", int'(d), int'(byte_at(11'h010)));
    bus_stop();

    // R9 repeated START mid-byte goes to address phase
    bus_start();
    send_byte(dev(3'b001, 1'b0), ack);
    send_byte(8'h20, ack);
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    bus_start();
    send_byte(dev(3'b001, 1'b1), ack);
    chk(ack, "R9 restart address ack", int'(ack), 1);
    recv_byte(1'b0, d);
    chk(d == byte_at(11'h120), "R9 restart read", int'(d), int'(byte_at(11'h120)));
    bus_stop();

    // R5 R8 write across the top of memory
    bus_start();
    send_byte(dev(3'b111, 1'b0), ack);
    send_byte(8'hFF, ack);
    exp_wa.push_back(11'h7FF); exp_wd.push_back(8'h11);
    exp_wa.push_back(11'h000); exp_wd.push_back(8'h22);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    chk(ack, "R4 data ack after wrap", int'(ack), 1);
    bus_stop();
    wq();
    chk(commits == 2, "R6 second commit", commits, 2);
    chk(exp_wa.size() == 0, "R5 wrap bytes handed", exp_wa.size(), 0);

    // R6 write cut by repeated START: no commit
    bus_start();
    send_byte(dev(3'b000, 1'b0), ack);
    send_byte(8'h40, ack);
    exp_wa.push_back(11'h040); exp_wd.push_back(8'h99);
    send_byte(8'h99, ack);
    bus_start();
    bus_stop();
    wq();
    chk(commits == 2, "R6 restart cancels commit", commits, 2);
    chk(sda_oe == 1'b0, "R10 idle oe", int'(sda_oe), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule